// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer for 9-bit words. It has a write port and a read port, and each port runs on its own clock. The two clocks may be unrelated or may be the same net. Status comes out as four active-low flags. The full and almost-full flags are produced in the write clock domain. The empty and almost-empty flags are produced in the read clock domain. The two almost thresholds are offset values supplied by a neighbouring sequencer as plain inputs.

A single input has a dual role, and its level while reset is held low decides which role it takes. If it is high during reset, it acts as a second write enable, which suits depth expansion. If it is low during reset, the block runs in threshold mode and the first write enable alone controls writes. Read data passes through an output register. An output-enable input gates it together with a data-valid qualifier, which stands in for a tri-state bus.

Top module: `dcfifo_progflag`

## Requirements
- R1: While rst_n is low, both pointers return to the first location and the output register clears to zero. The flags take these levels: full_n=1, afull_n=1, empty_n=0 and aempty_n=0.
- R2: If wen2_ld is 1 while reset is low, a word is written on a rising wclk edge only when wen1_n=0 and wen2_ld=1. If wen2_ld is 0 while reset is low, a word is written whenever wen1_n=0, and the run-time level of wen2_ld has no effect.
- R3: Words leave the block in the order they were written, with all 9 bits intact.
- R4: full_n goes low once DEPTH words are stored. Write attempts while full_n is low are discarded. full_n returns high after a read.
- R5: empty_n goes low once every stored word has been read. Read attempts while empty_n is low leave dout and the read pointer unchanged. empty_n returns high after a write.
- R6: A word moves into the output register on a rising rclk edge only when ren1_n=0 and ren2_n=0. If either read enable is 1, dout holds its value and no word is consumed.
- R7: aempty_n is low exactly when the stored word count is less than or equal to empty_ofs.
- R8: afull_n is low exactly when the free space (DEPTH minus the count) is less than or equal to full_ofs.
- R9: When oe_n=1, dout_vld is 0 and dout reads as zero. When oe_n=0, dout_vld is 1 and dout shows the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 9 | Write data |
| wen1_n | input | 1 | Primary write enable, active low |
| wen2_ld | input | 1 | Mode select during reset; second write enable (active high) in dual-enable mode |
| ren1_n | input | 1 | First read enable, active low |
| ren2_n | input | 1 | Second read enable, active low |
| oe_n | input | 1 | Output enable, active low |
| empty_ofs | input | log2(DEPTH) | Almost-empty threshold |
| full_ofs | input | log2(DEPTH) | Almost-full threshold |
| dout | output | 9 | Read data, zero when not enabled |
| dout_vld | output | 1 | Read data bus is driven |
| full_n | output | 1 | Full flag, active low, write domain |
| afull_n | output | 1 | Almost-full flag, active low, write domain |
| empty_n | output | 1 | Empty flag, active low, read domain |
| aempty_n | output | 1 | Almost-empty flag, active low, read domain |

## Verification
The bench builds the block with DEPTH=16, which makes a 4-bit address. At that depth the full boundary, the discarded write past full and the return from full can all be reached within a few dozen cycles. Both threshold edges, count at empty_ofs=2 and free space at full_ofs=3, can be reached from either side of the boundary. Both clock inputs are tied to one 50 MHz clock, which is the coincident-clock case. With a shared clock, the pointer synchronizer delay is a fixed number of cycles, so flags can be sampled after a settle time known in advance.

// File: rtl/fifo_pkg.sv
package fifo_pkg;
  typedef enum logic {
    WMODE_THRESH = 1'b0,
    WMODE_DUALWE = 1'b1
  } wmode_e;
endpackage

// File: rtl/rst_sync.sv
module rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 1'b0;
      srst_n  <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      srst_n  <= stage_q;
    end
  end
endmodule

// File: rtl/sync2.sv
module sync2 #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/dp_ram.sv
module dp_ram #(
  parameter int AW = 4,
  parameter int DW = 9
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/wr_side.sv
module wr_side
  import fifo_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          wen1_n,
  input  logic          wen2_ld,
  input  logic [AW:0]   rgray_s,
  input  logic [AW-1:0] full_ofs,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wgray,
  output logic          full_n,
  output logic          afull_n
);
  localparam logic [AW:0] DEPTH_V = {1'b1, {AW{1'b0}}};

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b = g;
    for (int k = 1; k <= AW; k++) begin
      b = b ^ (g >> k);
    end
    return b;
  endfunction

  wmode_e      mode_q;
  logic [AW:0] wbin_q, wbin_d, wgray_q, wgray_d;
  logic [AW:0] rbin_s, used_d, free_d;
  logic        full_q, full_d, afull_q, afull_d, wr_req;

  // Role of the dual-purpose pin is captured while the domain is in reset
  always_ff @(posedge wclk) begin
    if (!wrst_n) begin
      mode_q <= wmode_e'(wen2_ld);
    end
  end

  always_comb begin
    wr_req  = !wen1_n && ((mode_q == WMODE_THRESH) || wen2_ld);
    we      = wr_req && !full_q;
    wbin_d  = wbin_q + {{AW{1'b0}}, we};
    wgray_d = (wbin_d >> 1) ^ wbin_d;
    rbin_s  = g2b(rgray_s);
    used_d  = wbin_d - rbin_s;
    free_d  = DEPTH_V - used_d;
    full_d  = (wgray_d == {~rgray_s[AW:AW-1], rgray_s[AW-2:0]});
    afull_d = (free_d <= {1'b0, full_ofs});
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      full_q  <= 1'b0;
      afull_q <= 1'b0;
    end else begin
      if (we) begin
        wbin_q  <= wbin_d;
        wgray_q <= wgray_d;
      end
      full_q  <= full_d;
      afull_q <= afull_d;
    end
  end

  assign waddr   = wbin_q[AW-1:0];
  assign wgray   = wgray_q;
  assign full_n  = ~full_q;
  assign afull_n = ~afull_q;

  // R4: a full buffer accepts no write attempt
  a_r4_no_write_when_full: assert property (@(posedge wclk) disable iff (!wrst_n)
    (full_q && !wen1_n) |=> $stable(wgray_q));

  // R4: zero free space is always inside the almost-full window
  a_r4_full_implies_afull: assert property (@(posedge wclk) disable iff (!wrst_n)
    full_q |-> afull_q);
endmodule

// File: rtl/rd_side.sv
module rd_side #(
  parameter int AW = 4,
  parameter int DW = 9
) (
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          ren1_n,
  input  logic          ren2_n,
  input  logic [AW:0]   wgray_s,
  input  logic [AW-1:0] empty_ofs,
  input  logic [DW-1:0] rdata,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic [DW-1:0] dout_q,
  output logic          empty_n,
  output logic          aempty_n
);
  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b = g;
    for (int k = 1; k <= AW; k++) begin
      b = b ^ (g >> k);
    end
    return b;
  endfunction

  logic [AW:0] rbin_q, rbin_d, rgray_q, rgray_d, wbin_s, cnt_d;
  logic        re, empty_q, empty_d, aempty_q, aempty_d;

  always_comb begin
    re       = !ren1_n && !ren2_n && !empty_q;
    rbin_d   = rbin_q + {{AW{1'b0}}, re};
    rgray_d  = (rbin_d >> 1) ^ rbin_d;
    wbin_s   = g2b(wgray_s);
    cnt_d    = wbin_s - rbin_d;
    empty_d  = (rgray_d == wgray_s);
    aempty_d = (cnt_d <= {1'b0, empty_ofs});
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin_q   <= '0;
      rgray_q  <= '0;
      dout_q   <= '0;
      empty_q  <= 1'b1;
      aempty_q <= 1'b1;
    end else begin
      if (re) begin
        rbin_q  <= rbin_d;
        rgray_q <= rgray_d;
        dout_q  <= rdata;
      end
      empty_q  <= empty_d;
      aempty_q <= aempty_d;
    end
  end

  assign raddr    = rbin_q[AW-1:0];
  assign rgray    = rgray_q;
  assign empty_n  = ~empty_q;
  assign aempty_n = ~aempty_q;

  // R5: an empty buffer consumes no word
  a_r5_no_read_when_empty: assert property (@(posedge rclk) disable iff (!rrst_n)
    empty_q |=> $stable(rgray_q));

  // R6: a deasserted read enable freezes the output register
  a_r6_dout_hold: assert property (@(posedge rclk) disable iff (!rrst_n)
    (ren1_n || ren2_n) |=> $stable(dout_q));

  // R7: a count of zero always sits inside the almost-empty window
  a_r7_empty_implies_aempty: assert property (@(posedge rclk) disable iff (!rrst_n)
    empty_q |-> aempty_q);
endmodule

// File: rtl/dcfifo_progflag.sv
module dcfifo_progflag #(
  parameter int DEPTH = 1024,
  parameter int DW    = 9
) (
  input  logic                     wclk,
  input  logic                     rclk,
  input  logic                     rst_n,
  input  logic [DW-1:0]            din,
  input  logic                     wen1_n,
  input  logic                     wen2_ld,
  input  logic                     ren1_n,
  input  logic                     ren2_n,
  input  logic                     oe_n,
  input  logic [$clog2(DEPTH)-1:0] empty_ofs,
  input  logic [$clog2(DEPTH)-1:0] full_ofs,
  output logic [DW-1:0]            dout,
  output logic                     dout_vld,
  output logic                     full_n,
  output logic                     afull_n,
  output logic                     empty_n,
  output logic                     aempty_n
);
  localparam int AW = $clog2(DEPTH);

  logic          wrst_n, rrst_n, we;
  logic [AW-1:0] waddr, raddr;
  logic [AW:0]   wgray, rgray, wgray_s, rgray_s;
  logic [DW-1:0] rdata, dout_q;

  rst_sync u_wrst (.clk(wclk), .arst_n(rst_n), .srst_n(wrst_n));
  rst_sync u_rrst (.clk(rclk), .arst_n(rst_n), .srst_n(rrst_n));

  sync2 #(.W(AW+1)) u_r2w (.clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_s));
  sync2 #(.W(AW+1)) u_w2r (.clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_s));

  wr_side #(.AW(AW)) u_wr (
    .wclk(wclk), .wrst_n(wrst_n), .wen1_n(wen1_n), .wen2_ld(wen2_ld),
    .rgray_s(rgray_s), .full_ofs(full_ofs), .we(we), .waddr(waddr),
    .wgray(wgray), .full_n(full_n), .afull_n(afull_n)
  );

  dp_ram #(.AW(AW), .DW(DW)) u_ram (
    .wclk(wclk), .we(we), .waddr(waddr), .wdata(din),
    .raddr(raddr), .rdata(rdata)
  );

  rd_side #(.AW(AW), .DW(DW)) u_rd (
    .rclk(rclk), .rrst_n(rrst_n), .ren1_n(ren1_n), .ren2_n(ren2_n),
    .wgray_s(wgray_s), .empty_ofs(empty_ofs), .rdata(rdata),
    .raddr(raddr), .rgray(rgray), .dout_q(dout_q),
    .empty_n(empty_n), .aempty_n(aempty_n)
  );

  assign dout_vld = ~oe_n;
  assign dout     = oe_n ? '0 : dout_q;

  // R9: a disabled output never presents data
  a_r9_oe_gate: assert property (@(posedge rclk) disable iff (!rrst_n)
    !dout_vld |-> (dout == '0));
endmodule

// File: tb/sim_dcfifo_progflag.sv
module sim_dcfifo_progflag;
  localparam int DEPTH = 16;
  localparam int AW    = 4;

  logic          clk = 1'b0;
  logic          rst_n, wen1_n, wen2_ld, ren1_n, ren2_n, oe_n;
  logic [8:0]    din;
  logic [AW-1:0] empty_ofs, full_ofs;
  logic [8:0]    dout;
  logic          dout_vld, full_n, afull_n, empty_n, aempty_n;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  dcfifo_progflag #(.DEPTH(DEPTH), .DW(9)) u0 (
    .wclk(clk), .rclk(clk), .rst_n(rst_n), .din(din),
    .wen1_n(wen1_n), .wen2_ld(wen2_ld), .ren1_n(ren1_n), .ren2_n(ren2_n),
    .oe_n(oe_n), .empty_ofs(empty_ofs), .full_ofs(full_ofs),
    .dout(dout), .dout_vld(dout_vld), .full_n(full_n), .afull_n(afull_n),
    .empty_n(empty_n), .aempty_n(aempty_n)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic push(input logic [8:0] v);
    @(negedge clk);
    din    = v;
    wen1_n = 1'b0;
    @(negedge clk);
    wen1_n = 1'b1;
  endtask

  task automatic pop();
    @(negedge clk);
    ren1_n = 1'b0;
    ren2_n = 1'b0;
    @(negedge clk);
    ren1_n = 1'b1;
    ren2_n = 1'b1;
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk);
    rst_n   = 1'b0;
    wen2_ld = mode;
    wen1_n  = 1'b1;
    ren1_n  = 1'b1;
    ren2_n  = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n   = 1'b0;
    wen2_ld = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 full_n", full_n, 1);
    check("R1 afull_n", afull_n, 1);
    check("R1 empty_n", empty_n, 0);
    check("R1 aempty_n", aempty_n, 0);
    check("R1 dout", dout, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_thresh_mode();
    push(9'h0A1);
    push(9'h152);
    push(9'h0C3);
    settle();
    check("R5 empty_n after write", empty_n, 1);
    pop(); check("R3 word0", dout, 9'h0A1);
    pop(); check("R3 word1", dout, 9'h152);
    pop(); check("R2/R3 word2 with wen2_ld low", dout, 9'h0C3);
    settle();
    check("R5 empty_n after drain", empty_n, 0);
  endtask

  task automatic t_empty_read();
    pop();
    check("R5 read on empty holds dout", dout, 9'h0C3);
    push(9'h1D4);
    settle();
    pop();
    check("R5 pointer unmoved by empty read", dout, 9'h1D4);
    settle();
  endtask

  task automatic t_ren_hold();
    push(9'h0E5);
    push(9'h1F6);
    settle();
    @(negedge clk); ren1_n = 1'b0; ren2_n = 1'b1;
    @(negedge clk); ren1_n = 1'b1; ren2_n = 1'b1;
    check("R6 ren2 high holds", dout, 9'h1D4);
    @(negedge clk); ren1_n = 1'b1; ren2_n = 1'b0;
    @(negedge clk); ren1_n = 1'b1; ren2_n = 1'b1;
    check("R6 ren1 high holds", dout, 9'h1D4);
    pop(); check("R6 no word consumed", dout, 9'h0E5);
    pop(); check("R6 next word", dout, 9'h1F6);
    settle();
  endtask

  task automatic t_dual_mode();
    do_reset(1'b1);
    wen2_ld = 1'b0;
    push(9'h011);
    settle();
    check("R2 dual mode wen2 low blocks", empty_n, 0);
    wen2_ld = 1'b1;
    push(9'h022);
    settle();
    check("R2 dual mode write accepted", empty_n, 1);
    pop(); check("R2 only enabled word stored", dout, 9'h022);
    settle();
  endtask

  task automatic t_full();
    for (int i = 0; i < DEPTH; i++) push(9'h100 + 9'(i));
    check("R4 full_n low at depth", full_n, 0);
    push(9'h0AA);
    settle();
    check("R4 still full", full_n, 0);
    pop(); check("R4 first word", dout, 9'h100);
    settle();
    check("R4 full_n high after read", full_n, 1);
    push(9'h1FF);
    settle();
    for (int i = 1; i < DEPTH; i++) begin
      pop(); check("R4 word order past full", dout, 9'h100 + 9'(i));
    end
    pop(); check("R4 discarded write absent", dout, 9'h1FF);
    settle();
  endtask

  task automatic t_aempty();
    empty_ofs = 4'd2;
    push(9'h031); push(9'h032);
    settle();
    check("R7 count=ofs asserts", aempty_n, 0);
    push(9'h033);
    settle();
    check("R7 count>ofs clears", aempty_n, 1);
    pop(); pop(); pop();
    settle();
    check("R7 count 0", aempty_n, 0);
    empty_ofs = 4'd0;
  endtask

  task automatic t_afull();
    full_ofs = 4'd3;
    for (int i = 0; i < 12; i++) push(9'h040 + 9'(i));
    settle();
    check("R8 free 4 clear", afull_n, 1);
    push(9'h04C);
    settle();
    check("R8 free=ofs asserts", afull_n, 0);
    check("R4 not full at 13", full_n, 1);
    pop();
    settle();
    check("R8 after read clears", afull_n, 1);
    for (int i = 0; i < 12; i++) pop();
    settle();
    full_ofs = 4'd0;
  endtask

  task automatic t_oe();
    push(9'h155);
    settle();
    pop();
    check("R9 enabled data", dout, 9'h155);
    check("R9 enabled valid", dout_vld, 1);
    @(negedge clk); oe_n = 1'b1; #1;
    check("R9 disabled data", dout, 0);
    check("R9 disabled valid", dout_vld, 0);
    @(negedge clk); oe_n = 1'b0; #1;
    check("R9 re-enabled data", dout, 9'h155);
  endtask

  initial begin
    rst_n = 1'b0; wen1_n = 1'b1; wen2_ld = 1'b0; ren1_n = 1'b1; ren2_n = 1'b1;
    oe_n = 1'b0; din = '0; empty_ofs = '0; full_ofs = '0;
    t_reset();
    t_thresh_mode();
    t_empty_read();
    t_ren_hold();
    t_dual_mode();
    t_full();
    t_aempty();
    t_afull();
    t_oe();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R1 actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule